// File: doc/BRIEF.md
# Phase Detector Digital Lock Detector

This block decides whether a phase-locked loop has settled by watching the two clock edges that meet at its phase-frequency detector. The first edge is the divided reference and the second is the divided feedback. It samples both signals with a fast local clock. It sees one comparison cycle as a pair of rising edges. It counts the sampling ticks between the first edge of the pair and the second, and that count is the phase error of the cycle.

The lock flag is a hysteresis state machine. While unlocked, it counts how many comparison cycles in a row had an error strictly below the lock threshold. When that run reaches `QUAL_CYCLES`, the flag goes high. A single cycle that is not tight clears the run. Once the flag is high, it stays high until one comparison shows an error at or above the wider unlock threshold. Both thresholds are inputs, given in sampling ticks. If one edge arrives and its partner has not arrived after `TIMEOUT` ticks, the cycle is closed as a large error. This handles a missing or stopped clock.

Top module: `pfd_lock_detect`

## Requirements
- R1: Reset (active-low `rst_n`) forces `locked` low and clears the qualification run. The next lock after reset needs a full run of `QUAL_CYCLES` tight comparisons.
- R2: The phase error of a comparison is the number of sampling ticks between the rising edge that leads and the rising edge that lags. Either input may lead. Edges in the same tick give an error of 0.
- R3: While unlocked, `locked` rises after `QUAL_CYCLES` (5 by default) consecutive comparisons, each with error < `lock_thr`. After one fewer such comparison it stays low.
- R4: While unlocked, a comparison with error >= `lock_thr` clears the run of tight comparisons to zero.
- R5: While locked, comparisons with error < `unlock_thr` leave `locked` high. This includes errors between the two thresholds.
- R6: While locked, a single comparison with error >= `unlock_thr` drops `locked`. Regaining lock then needs a fresh full run of tight comparisons.
- R7: If the partner edge does not arrive within `TIMEOUT` (64) ticks of the leading edge, the comparison counts as a large error. It drops the lock, or clears the run when unlocked.
- R8: `locked` changes only in the cycle that follows a completed comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock seen by the phase detector (asynchronous) |
| fb_in | input | 1 | Feedback clock seen by the phase detector (asynchronous) |
| lock_thr | input | CNT_W (7) | Lock threshold in ticks; an error strictly below it is tight |
| unlock_thr | input | CNT_W (7) | Unlock threshold in ticks; an error at or above it breaks lock |
| locked | output | 1 | Active-high lock indication |

## Verification
A wrong internal state shows up only on `locked`, and only at a comparison boundary. Some faults affect a run of comparisons rather than a single one. An off-by-one in the tick count moves the lock or unlock decision by exactly one tick at a threshold. A run counter that fails to clear lets lock come back too early after an interrupted run. A lost timeout never closes a one-sided cycle. Each of these faults becomes visible within a few sampling cycles of the comparison that should have decided the flag. The directed scenarios therefore place errors exactly at, just below and just above each threshold. They also break runs one comparison short of `QUAL_CYCLES`.

// File: rtl/pld_pkg.sv
package pld_pkg;

  localparam int unsigned ARG_W = 16;

  // Returns 1 when a comparison result may extend the qualification run.
  function automatic logic err_tight(input logic [ARG_W-1:0] err,
                                     input logic             timed_out,
                                     input logic [ARG_W-1:0] thr);
    return !timed_out && (err < thr);
  endfunction

  // Returns 1 when a comparison result breaks an established lock.
  function automatic logic err_loose(input logic [ARG_W-1:0] err,
                                     input logic             timed_out,
                                     input logic [ARG_W-1:0] thr);
    return timed_out || (err >= thr);
  endfunction

endpackage

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] && !last;

endmodule

// File: rtl/pld_phase_meter.sv
module pld_phase_meter #(
  parameter int unsigned TIMEOUT = 64,
  parameter int unsigned CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             fb_rise,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_err,
  output logic             meas_timeout
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic             waiting;
  logic             lead_ref;
  logic [CNT_W-1:0] ticks;
  logic             partner;

  assign partner = lead_ref ? fb_rise : ref_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting      <= 1'b0;
      lead_ref     <= 1'b0;
      ticks        <= '0;
      meas_valid   <= 1'b0;
      meas_err     <= '0;
      meas_timeout <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      if (!waiting) begin
        if (ref_rise && fb_rise) begin
          meas_valid   <= 1'b1;
          meas_err     <= '0;
          meas_timeout <= 1'b0;
        end else if (ref_rise || fb_rise) begin
          waiting  <= 1'b1;
          lead_ref <= ref_rise;
          ticks    <= CNT_W'(1);
        end
      end else if (partner) begin
        waiting      <= 1'b0;
        meas_valid   <= 1'b1;
        meas_err     <= ticks;
        meas_timeout <= 1'b0;
      end else if (ticks == LIMIT) begin
        waiting      <= 1'b0;
        meas_valid   <= 1'b1;
        meas_err     <= ticks;
        meas_timeout <= 1'b1;
      end else begin
        ticks <= ticks + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/pld_qualifier.sv
module pld_qualifier #(
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned QUAL_CYCLES = 5,
  parameter int unsigned QW          = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_valid,
  input  logic [CNT_W-1:0] meas_err,
  input  logic             meas_timeout,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] unlock_thr,
  output logic             tight,
  output logic             loose,
  output logic [QW-1:0]    qual_cnt,
  output logic             locked
);

  localparam logic [QW-1:0] LAST = QW'(QUAL_CYCLES - 1);

  assign tight = pld_pkg::err_tight(pld_pkg::ARG_W'(meas_err), meas_timeout,
                                    pld_pkg::ARG_W'(lock_thr));
  assign loose = pld_pkg::err_loose(pld_pkg::ARG_W'(meas_err), meas_timeout,
                                    pld_pkg::ARG_W'(unlock_thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      qual_cnt <= '0;
    end else if (meas_valid) begin
      if (!locked) begin
        if (!tight) begin
          qual_cnt <= '0;
        end else if (qual_cnt == LAST) begin
          locked   <= 1'b1;
          qual_cnt <= '0;
        end else begin
          qual_cnt <= qual_cnt + QW'(1);
        end
      end else if (loose) begin
        locked   <= 1'b0;
        qual_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect #(
  parameter int unsigned TIMEOUT     = 64,
  parameter int unsigned QUAL_CYCLES = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] unlock_thr,
  output logic             locked
);

  localparam int unsigned QW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;

  // Named internal events, observed by the bound checker.
  logic             ref_rise;
  logic             fb_rise;
  logic             meas_valid;
  logic [CNT_W-1:0] meas_err;
  logic             meas_timeout;
  logic             tight;
  logic             loose;
  logic [QW-1:0]    qual_cnt;

  pld_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
    .clk(clk), .rst_n(rst_n), .async_in(ref_in), .rise(ref_rise)
  );

  pld_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_fb (
    .clk(clk), .rst_n(rst_n), .async_in(fb_in), .rise(fb_rise)
  );

  pld_phase_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n),
    .ref_rise(ref_rise), .fb_rise(fb_rise),
    .meas_valid(meas_valid), .meas_err(meas_err), .meas_timeout(meas_timeout)
  );

  pld_qualifier #(.CNT_W(CNT_W), .QUAL_CYCLES(QUAL_CYCLES), .QW(QW)) u_qual (
    .clk(clk), .rst_n(rst_n),
    .meas_valid(meas_valid), .meas_err(meas_err), .meas_timeout(meas_timeout),
    .lock_thr(lock_thr), .unlock_thr(unlock_thr),
    .tight(tight), .loose(loose), .qual_cnt(qual_cnt), .locked(locked)
  );

endmodule

// File: rtl/pld_checker.sv
module pld_checker #(
  parameter int unsigned TIMEOUT     = 64,
  parameter int unsigned QUAL_CYCLES = 5,
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned QW          = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] lock_thr,
  input logic [CNT_W-1:0] unlock_thr,
  input logic             locked,
  input logic             meas_valid,
  input logic [CNT_W-1:0] meas_err,
  input logic             meas_timeout,
  input logic [QW-1:0]    qual_cnt
);

  // R3: a lock is only granted right after a tight comparison
  p_lock_on_tight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_valid && !meas_timeout && (meas_err < lock_thr)));

  // R6: a lock is only lost right after a loose comparison
  p_unlock_on_loose_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(meas_valid && (meas_timeout || (meas_err >= unlock_thr))));

  // R4: a non-tight comparison while unlocked empties the run
  p_run_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !locked && (meas_timeout || (meas_err >= lock_thr))) |=> (qual_cnt == '0));

  // R7: a timed-out comparison reports the full window
  p_timeout_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && meas_timeout) |-> (meas_err == CNT_W'(TIMEOUT)));

  // R8: no comparison, no change on the flag
  p_flag_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> $stable(locked));

  // R3: run counter never reaches the qualification length
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qual_cnt < QW'(QUAL_CYCLES));

  // R1: leaving reset starts unlocked
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!locked && (qual_cnt == '0)));

endmodule

bind pfd_lock_detect pld_checker #(
  .TIMEOUT(TIMEOUT), .QUAL_CYCLES(QUAL_CYCLES), .CNT_W(CNT_W), .QW(QW)
) u_pld_checker (
  .clk(clk), .rst_n(rst_n), .lock_thr(lock_thr), .unlock_thr(unlock_thr),
  .locked(locked), .meas_valid(meas_valid), .meas_err(meas_err),
  .meas_timeout(meas_timeout), .qual_cnt(qual_cnt)
);

// File: tb/sim_pfd_lock_detect.sv
module sim_pfd_lock_detect;

  localparam int CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_in = 1'b0;
  logic             fb_in = 1'b0;
  logic [CNT_W-1:0] lock_thr = CNT_W'(3);
  logic [CNT_W-1:0] unlock_thr = CNT_W'(5);
  logic             locked;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pfd_lock_detect u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .lock_thr(lock_thr), .unlock_thr(unlock_thr), .locked(locked)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: locked actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One comparison: leading input rises, the other follows d ticks later.
  task automatic compare(input bit ref_leads, input int d);
    @(negedge clk);
    if (d == 0) begin
      ref_in = 1'b1; fb_in = 1'b1;
    end else begin
      if (ref_leads) ref_in = 1'b1; else fb_in = 1'b1;
      ticks(d);
      if (ref_leads) fb_in = 1'b1; else ref_in = 1'b1;
    end
    ticks(3);
    ref_in = 1'b0; fb_in = 1'b0;
    ticks(12);
  endtask

  task automatic run(input int n, input int d);
    for (int i = 0; i < n; i++) compare(i[0], d);
  endtask

  // Only one edge arrives; the window must expire.
  task automatic lone_edge(input bit on_ref);
    @(negedge clk);
    if (on_ref) ref_in = 1'b1; else fb_in = 1'b1;
    ticks(4);
    ref_in = 1'b0; fb_in = 1'b0;
    ticks(90);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ticks(3);
    rst_n = 1'b1;
    ticks(3);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 unlocked after reset", locked, 1'b0);
  endtask

  task automatic t_qualify();
    run(4, 1);
    check("R3 four tight cycles not enough", locked, 1'b0);
    compare(1'b0, 2);
    check("R3 fifth tight cycle locks (fb leads)", locked, 1'b1);
  endtask

  task automatic t_hold();
    run(3, 4);
    check("R5 error between thresholds keeps lock", locked, 1'b1);
    compare(1'b1, 0);
    check("R5 zero error keeps lock", locked, 1'b1);
  endtask

  task automatic t_unlock();
    compare(1'b1, 5);
    check("R6 error equal to unlock threshold drops lock", locked, 1'b0);
    run(4, 1);
    check("R6 relock needs a full run", locked, 1'b0);
    compare(1'b1, 1);
    check("R6 relock after full run", locked, 1'b1);
  endtask

  task automatic t_run_clear();
    compare(1'b0, 6);
    check("R6 large error drops lock", locked, 1'b0);
    run(4, 2);
    compare(1'b1, 3);
    run(4, 2);
    check("R4 error equal to lock threshold restarts run", locked, 1'b0);
    compare(1'b0, 2);
    check("R4 lock after restarted run completes", locked, 1'b1);
  endtask

  task automatic t_timeout();
    lone_edge(1'b1);
    check("R7 missing feedback edge drops lock", locked, 1'b0);
    run(4, 1);
    lone_edge(1'b0);
    compare(1'b1, 1);
    check("R7 missing reference edge clears run", locked, 1'b0);
    run(4, 1);
    check("R7 lock after fresh run", locked, 1'b1);
  endtask

  task automatic t_exact_distance();
    compare(1'b1, 6);
    lock_thr = CNT_W'(1);
    unlock_thr = CNT_W'(2);
    run(5, 0);
    check("R2 simultaneous edges measure zero", locked, 1'b1);
    compare(1'b0, 1);
    check("R2 one tick lead measures one", locked, 1'b1);
    compare(1'b1, 2);
    check("R2 two tick lead measures two", locked, 1'b0);
    lock_thr = CNT_W'(3);
    unlock_thr = CNT_W'(5);
  endtask

  task automatic t_reset_mid();
    run(5, 1);
    check("R3 locked before reset", locked, 1'b1);
    do_reset();
    check("R1 reset clears lock", locked, 1'b0);
    run(4, 1);
    check("R1 reset cleared the run", locked, 1'b0);
    compare(1'b1, 1);
    check("R1 lock after full run post reset", locked, 1'b1);
  endtask

  task automatic t_latency();
    int seen;
    compare(1'b1, 6);
    run(4, 1);
    @(negedge clk);
    ref_in = 1'b1; fb_in = 1'b1;
    seen = -1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (locked && seen < 0) seen = i;
    end
    ref_in = 1'b0; fb_in = 1'b0;
    checks++;
    if (seen != 3) begin
      failures++;
      $display("FAIL R8: lock delay actual=%0d expected=3", seen);
    end
    ticks(10);
  endtask

  initial begin
    t_reset();
    t_qualify();
    t_hold();
    t_unlock();
    t_run_clear();
    t_timeout();
    t_exact_distance();
    t_reset_mid();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule